// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Programmable Fill Flags

This block carries 36-bit words from a write clock domain to an unrelated read clock domain. Words enter through a valid/ready stream. A word is accepted on a write-clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the source must hold its word and keep `in_valid` asserted. The read side presents the oldest word in an output register without any request. That word is consumed on a read-clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold steady.

The word held in the output register is not counted as stored. The fill level `m` used by every flag counts only the words still in memory. Each flag is generated in the clock domain of its own port:
- `rd_aempty_n` is generated in the read domain and goes low when memory is nearly empty.
- `wr_afull_n` is generated in the write domain and goes low when memory is nearly full.

The near-empty offset X and the near-full offset Y come from one of three presets picked by `cfg_sel` while reset is applied. In a fourth mode they can instead be written from the write side. Pointers cross between the domains in gray code through two-flop synchronizers. A change made by one side therefore reaches the other side's flags on that side's second clock edge. `DEPTH` must be a power of two and at least 64. Offsets are treated as static while data is in flight.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: A word written into a completely empty FIFO moves into the output register with no read request, and `out_valid` rises on the third read-clock edge after the write edge.
- R2: Words leave in write order; while `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R3: The memory count `m` excludes the output register: after k ≥ 1 words are written and none are read, m = k−1. `in_ready` is low exactly when m equals DEPTH.
- R4: `rd_aempty_n` is 0 while m ≤ X and 1 while m ≥ X+1.
- R5: After a write that raises m from X to X+1, `rd_aempty_n` stays 0 after the first read-clock edge and is 1 after the second.
- R6: With memory full, after a read that frees a slot, `in_ready` stays 0 after the first write-clock edge and is 1 after the second.
- R7: `wr_afull_n` is 0 while m ≥ DEPTH−Y and 1 while m < DEPTH−Y.
- R8: `out_valid` is 0 whenever both memory and the output register are empty.
- R9: While reset is applied, `cfg_sel` picks X = Y = 8 (value 0), 16 (value 1) or 64 (value 2). In these modes `cfg_we` has no effect.
- R10: With `cfg_sel` = 3 during reset, a write-clock edge with `cfg_we` high loads X from `cfg_ae` and Y from `cfg_af`.
- R11: Asynchronous reset (`rst_n` low) empties the FIFO and forces `in_ready` and `out_valid` low at once. After release, `in_ready` is 0 following the first write-clock edge and 1 following the second.
- R12: A write offered while `in_ready` is low and a read offered while `out_valid` is low are ignored and change no stored word or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write-side clock |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Space available; write accepted when both high |
| in_data | input | DATA_W | Write word |
| wr_afull_n | output | 1 | Low when memory holds DEPTH−Y words or more (write clock) |
| cfg_sel | input | 2 | Offset mode sampled during reset: 0→8, 1→16, 2→64, 3→programmed |
| cfg_we | input | 1 | Load offsets from cfg_ae/cfg_af (mode 3 only) |
| cfg_ae | input | log2(DEPTH)+1 | Near-empty offset X to program |
| cfg_af | input | log2(DEPTH)+1 | Near-full offset Y to program |
| rclk | input | 1 | Read-side clock |
| out_valid | output | 1 | Output register holds a word |
| out_ready | input | 1 | Consumer takes the word when both high |
| out_data | output | DATA_W | Oldest word |
| rd_aempty_n | output | 1 | Low when memory holds X words or fewer (read clock) |

## Verification
Each damaged pointer, gray conversion or count shows at the ports within one settling interval. It appears as one of these:
- a flag at the wrong level;
- a lost, repeated or reordered word in the drained sequence;
- a phantom word after the FIFO should be empty.

A synchronizer that is one stage too short or too long moves `out_valid`, `rd_aempty_n` or `in_ready` one edge early or late. The bench counts edges from the causing transfer to catch this. Miscounting the output register as memory shifts every flag by one fill level across the full sweep, so the error shows at the first threshold.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic [1:0] {
    OFS_8    = 2'd0,
    OFS_16   = 2'd1,
    OFS_64   = 2'd2,
    OFS_PROG = 2'd3
  } ofs_mode_e;

  // Preset offset for a reset-time mode select.
  function automatic int unsigned preset_ofs(input logic [1:0] sel);
    case (sel)
      2'd1:    return 16;
      2'd2:    return 64;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer with asynchronous clear; also used as reset synchronizer.
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
// Storage array: written in the write domain, read combinationally by the read side.
module dcf_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
// Write-domain control: write pointer, space flag, near-full flag, offset registers.
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wgray,
  input  logic [PW-1:0]     rgray_s,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_we,
  input  logic [PW-1:0]     cfg_ae,
  input  logic [PW-1:0]     cfg_af,
  output logic [PW-1:0]     ae_ofs,
  output logic              afull_n,
  output logic [PW-1:0]     wcnt
);
  logic [PW-1:0] wbin, wbin_nx, rbin_s;
  logic [PW-1:0] af_ofs;
  logic [PW:0]   af_sum;
  logic          prog_mode;
  logic          push;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign wcnt     = wbin - rbin_s;
  assign in_ready = wrst_n && (wcnt != PW'(DEPTH));
  assign push     = in_valid && in_ready;
  assign wr_en    = push;
  assign waddr    = wbin[ADDR_W-1:0];
  assign wbin_nx  = wbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // Offsets: presets captured while reset is held, programmable afterwards in mode 3.
  always_ff @(posedge wclk) begin
    if (!wrst_n) begin
      prog_mode <= (cfg_sel == OFS_PROG);
      ae_ofs    <= PW'(preset_ofs(cfg_sel));
      af_ofs    <= PW'(preset_ofs(cfg_sel));
    end else if (prog_mode && cfg_we) begin
      ae_ofs <= cfg_ae;
      af_ofs <= cfg_af;
    end
  end

  assign af_sum  = {1'b0, wcnt} + {1'b0, af_ofs};
  assign afull_n = (af_sum < (PW+1)'(DEPTH));
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
// Read-domain control: read pointer, fall-through output register, near-empty flag.
module dcf_rd_ctl #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 8,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              rclk,
  input  logic              rrst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic [PW-1:0]     rgray,
  input  logic [PW-1:0]     wgray_s,
  input  logic [PW-1:0]     ae_ofs,
  output logic              aempty_n,
  output logic [PW-1:0]     rcnt
);
  logic [PW-1:0] rbin, rbin_nx, wbin_s;
  logic          pop, load;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign rcnt     = wbin_s - rbin;
  assign pop      = out_valid && out_ready;
  assign load     = (rcnt != '0) && (!out_valid || pop);
  assign raddr    = rbin[ADDR_W-1:0];
  assign rbin_nx  = rbin + 1'b1;
  assign aempty_n = (rcnt > ae_ofs);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_data  <= rdata;
      rbin      <= rbin_nx;
      rgray     <= rbin_nx ^ (rbin_nx >> 1);
      out_valid <= 1'b1;
    end else if (pop) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xclk_fwft_fifo.sv
`timescale 1ns/1ps
module xclk_fwft_fifo #(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_afull_n,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_ae,
  input  logic [CNT_W-1:0]  cfg_af,
  input  logic              rclk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              rd_aempty_n
);
  logic              wrst_n_q, rrst_n_q;
  logic [CNT_W-1:0]  wgray, rgray, wgray_s, rgray_s;
  logic [CNT_W-1:0]  wcnt, rcnt, ae_ofs;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;

  // Per-domain reset synchronizers: asynchronous assert, two-edge release.
  dcf_sync #(.W(1)) u_wrst (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(wrst_n_q));
  dcf_sync #(.W(1)) u_rrst (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(rrst_n_q));

  // Gray pointer crossings.
  dcf_sync #(.W(CNT_W)) u_w2r (.clk(rclk), .rst_n(rrst_n_q), .d(wgray), .q(wgray_s));
  dcf_sync #(.W(CNT_W)) u_r2w (.clk(wclk), .rst_n(wrst_n_q), .d(rgray), .q(rgray_s));

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk (wclk),
    .we   (wr_en),
    .waddr(waddr),
    .wdata(in_data),
    .raddr(raddr),
    .rdata(rdata)
  );

  dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .wclk    (wclk),
    .wrst_n  (wrst_n_q),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .wr_en   (wr_en),
    .waddr   (waddr),
    .wgray   (wgray),
    .rgray_s (rgray_s),
    .cfg_sel (cfg_sel),
    .cfg_we  (cfg_we),
    .cfg_ae  (cfg_ae),
    .cfg_af  (cfg_af),
    .ae_ofs  (ae_ofs),
    .afull_n (wr_afull_n),
    .wcnt    (wcnt)
  );

  dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk     (rclk),
    .rrst_n   (rrst_n_q),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .raddr    (raddr),
    .rdata    (rdata),
    .rgray    (rgray),
    .wgray_s  (wgray_s),
    .ae_ofs   (ae_ofs),
    .aempty_n (rd_aempty_n),
    .rcnt     (rcnt)
  );
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 9,
  parameter int DATA_W = 36
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst_n_q,
  input logic              rrst_n_q,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              rd_aempty_n,
  input logic [CNT_W-1:0]  wcnt,
  input logic [CNT_W-1:0]  rcnt
);
  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n_q)
    wcnt <= CNT_W'(DEPTH));

  // R3
  no_overread_chk: assert property (@(posedge rclk) disable iff (!rrst_n_q)
    rcnt <= CNT_W'(DEPTH));

  // R2
  hold_out_chk: assert property (@(posedge rclk) disable iff (!rrst_n_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  aempty_valid_chk: assert property (@(posedge rclk) disable iff (!rrst_n_q)
    rd_aempty_n |=> out_valid);

  // R12
  ignored_wr_chk: assert property (@(posedge wclk) disable iff (!wrst_n_q)
    !(in_valid && in_ready) |=> (wcnt <= $past(wcnt)));
endmodule

bind xclk_fwft_fifo dcf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .wclk       (wclk),
  .rclk       (rclk),
  .wrst_n_q   (wrst_n_q),
  .rrst_n_q   (rrst_n_q),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .rd_aempty_n(rd_aempty_n),
  .wcnt       (wcnt),
  .rcnt       (rcnt)
);

// File: tb/xclk_fwft_fifo_tb_top.sv
`timescale 1ns/1ps
module xclk_fwft_fifo_tb_top;
  localparam int      DATA_W      = 36;
  localparam int      DEPTH       = 64;
  localparam int      CNT_W       = $clog2(DEPTH) + 1;
  localparam realtime WCLK_PERIOD = 10.0;
  localparam realtime RCLK_PERIOD = 14.0;
  localparam realtime SKEW        = 0.5;
  localparam realtime SETTLE      = RCLK_PERIOD * 12;

  logic              rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
  logic              in_valid = 1'b0, cfg_we = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [1:0]        cfg_sel = 2'd3;
  logic [CNT_W-1:0]  cfg_ae = '0, cfg_af = '0;
  logic              in_ready, out_valid, wr_afull_n, rd_aempty_n;
  logic [DATA_W-1:0] out_data;
  int n_run = 0, n_fail = 0;

  xclk_fwft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .rst_n(rst_n), .wclk(wclk), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_afull_n(wr_afull_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_ae(cfg_ae), .cfg_af(cfg_af), .rclk(rclk), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .rd_aempty_n(rd_aempty_n)
  );

  // Write edges at 5+10k, read edges at 8+14m: never coincident.
  always #(WCLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #1;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input int ci, input int k);
    return {4'(ci), 16'hC0DE, 16'(k)};
  endfunction

  task automatic push(input logic [DATA_W-1:0] d);
    @(posedge wclk); #(SKEW);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) begin @(posedge wclk); #(SKEW); end
    @(posedge wclk); #(SKEW);
    in_valid = 1'b0;
  endtask

  task automatic pop(input logic [DATA_W-1:0] e, input string tag);
    @(posedge rclk); #(SKEW);
    out_ready = 1'b1;
    while (!out_valid) begin @(posedge rclk); #(SKEW); end
    chk({tag, " R2 order"}, out_data, e);
    @(posedge rclk); #(SKEW);
    out_ready = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    cfg_sel = sel; rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; cfg_we = 1'b0;
    #(RCLK_PERIOD*4);
    @(posedge wclk); #(SKEW); rst_n = 1'b1;
    #(RCLK_PERIOD*4);
  endtask

  task automatic program_ofs(input int x, input int y);
    @(posedge wclk); #(SKEW);
    cfg_ae = CNT_W'(x); cfg_af = CNT_W'(y); cfg_we = 1'b1;
    @(posedge wclk); #(SKEW);
    cfg_we = 1'b0;
  endtask

  task automatic chk_level(input int m, input bit ov, input int x, input int y, input string ctx);
    chk($sformatf("%s %s out_valid m=%0d", ctx, ov ? "R1" : "R8", m), out_valid, ov);
    chk($sformatf("%s R4 aempty_n m=%0d X=%0d", ctx, m, x), rd_aempty_n, m > x);
    chk($sformatf("%s R7 afull_n m=%0d Y=%0d", ctx, m, y), wr_afull_n, (m + y) < DEPTH);
    chk($sformatf("%s R3 in_ready m=%0d", ctx, m), in_ready, m < DEPTH);
  endtask

  // Full fill and drain sweep for one offset configuration.
  task automatic sweep(input logic [1:0] sel, input int x, input int y, input int ci, input string ctx);
    do_reset(sel);
    if (sel == 2'd3) program_ofs(x, y);   // R10
    else program_ofs(1, 1);               // R9: must be ignored
    #(SETTLE);
    chk_level(0, 1'b0, x, y, {ctx, " empty"});
    for (int k = 1; k <= DEPTH + 1; k++) begin
      push(word(ci, k));
      #(SETTLE);
      chk_level(k - 1, 1'b1, x, y, {ctx, " fill"});
    end
    if (ci == 0) begin
      // R12: writes offered while full are dropped
      @(posedge wclk); #(SKEW);
      in_valid = 1'b1; in_data = '1;
      repeat (5) @(posedge wclk);
      #(SKEW); in_valid = 1'b0;
      #(SETTLE);
      chk("R12 in_ready stays low when full", in_ready, 1'b0);
    end
    for (int k = 1; k <= DEPTH + 1; k++) begin
      int left;
      pop(word(ci, k), ctx);
      #(SETTLE);
      left = DEPTH + 1 - k;
      chk_level(left > 0 ? left - 1 : 0, left > 0, x, y, {ctx, " drain"});
    end
  endtask

  task automatic edge_tests();
    do_reset(2'd3);
    program_ofs(2, 2);
    #(SETTLE);
    // R1: fall-through on third read edge
    push(word(9, 1));
    for (int e = 1; e <= 3; e++) begin
      @(posedge rclk); #(SKEW);
      chk($sformatf("R1 out_valid after read edge %0d", e), out_valid, e == 3);
    end
    push(word(9, 2));
    push(word(9, 3));
    #(SETTLE);
    chk("R5 aempty_n low at m=X", rd_aempty_n, 1'b0);
    push(word(9, 4));
    for (int e = 1; e <= 2; e++) begin
      @(posedge rclk); #(SKEW);
      chk($sformatf("R5 aempty_n after read edge %0d", e), rd_aempty_n, e == 2);
    end
    for (int k = 5; k <= DEPTH + 1; k++) push(word(9, k));
    #(SETTLE);
    chk("R3 in_ready low when memory full", in_ready, 1'b0);
    pop(word(9, 1), "R6");
    for (int e = 1; e <= 2; e++) begin
      @(posedge wclk); #(SKEW);
      chk($sformatf("R6 in_ready after write edge %0d", e), in_ready, e == 2);
    end

    // R11: asynchronous reset and release timing
    #(1.3);
    rst_n = 1'b0;
    #(SKEW);
    chk("R11 in_ready low in reset", in_ready, 1'b0);
    chk("R11 out_valid low in reset", out_valid, 1'b0);
    #(RCLK_PERIOD*3);
    @(posedge wclk); #(SKEW); rst_n = 1'b1;
    for (int e = 1; e <= 2; e++) begin
      @(posedge wclk); #(SKEW);
      chk($sformatf("R11 in_ready after release edge %0d", e), in_ready, e == 2);
    end
    #(SETTLE);
    chk("R11 out_valid empty after reset", out_valid, 1'b0);

    // R12: reads offered while empty are dropped
    @(posedge rclk); #(SKEW); out_ready = 1'b1;
    repeat (5) @(posedge rclk);
    #(SKEW); out_ready = 1'b0;
    #(SETTLE);
    chk("R12 out_valid stays low when empty", out_valid, 1'b0);
    push(word(10, 1));
    #(SETTLE);
    chk("R12 first word after empty reads", out_valid, 1'b1);
    chk("R12 no phantom word", out_data, word(10, 1));
    // R2: hold under back-pressure
    push(word(10, 2));
    repeat (6) @(posedge rclk);
    #(SKEW);
    chk("R2 out_valid held", out_valid, 1'b1);
    chk("R2 out_data held", out_data, word(10, 1));
    pop(word(10, 1), "R2a");
    pop(word(10, 2), "R2b");
    #(SETTLE);
    chk("R8 out_valid low after drain", out_valid, 1'b0);
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(SKEW);
    chk("R11 in_ready low at start", in_ready, 1'b0);
    chk("R11 out_valid low at start", out_valid, 1'b0);
    sweep(2'd3, 0, 0, 0, "R10 prog X0Y0");
    sweep(2'd3, 5, 9, 1, "R10 prog X5Y9");
    sweep(2'd3, 20, 3, 2, "R10 prog X20Y3");
    sweep(2'd3, 63, 63, 3, "R10 prog X63Y63");
    sweep(2'd0, 8, 8, 4, "R9 preset8");
    sweep(2'd1, 16, 16, 5, "R9 preset16");
    sweep(2'd2, 64, 64, 6, "R9 preset64");
    edge_tests();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule